// File: doc/BRIEF.md
# Five-Hot Position Encoder

This block takes a 16-bit vector that should have exactly five bits set and returns the bit index of each of those five bits as a packed 20-bit word. The five 4-bit fields are in descending order, so the most significant set bit appears in the top field. The word is meant to be written into a wide queue and read back by a consumer that handles all five indices in parallel.

The vector is split into a low byte and a high byte, and each byte addresses its own lookup table. The tables are computed when the design is elaborated. The low-byte table places its indices at the least significant end of the word and also returns how many bits it found. The high-byte table places its indices at the most significant end. Once the lookup has been registered, each output field takes either the low-table field or the high-table field. That choice depends only on the low-byte count, so every output bit is a single 2:1 select. A separate popcount flags any input that does not have exactly five bits set.

Top module: `fh_index_encoder`

## Requirements
- R1: When a result is valid and not flagged, idx_o holds the five set-bit indices in strictly descending order. The largest index is in bits [19:16], then [15:12], [11:8], [7:4], and the smallest is in bits [3:0].
- R2: The input 16'hC007 (bits 15, 14, 2, 1 and 0 set) produces idx_o = 20'hFE210.
- R3: If the low byte holds c set bits (c from 0 to 5), the c smallest indices sit in the bottom c fields and the high-byte indices fill the fields above them. This holds for any split between the two bytes, including c = 0 and c = 5.
- R4: The block accepts a new vector on every cycle in which valid_i is 1, and the results leave in the same order they arrived.
- R5: valid_o equals valid_i from exactly two clock cycles earlier.
- R6: err_o is 1 together with valid_o when the input that produced the result does not have exactly five bits set. Otherwise err_o is 0. err_o is never 1 while valid_o is 0.
- R7: For a flagged input with fewer than five set bits, the high-byte indices fill fields from [19:16] downward and the low-byte indices fill fields from [3:0] upward. Every field left over reads 4'h0. An all-zero input therefore gives 20'h00000.
- R8: While rst_ni is low, valid_o and err_o read 0. This takes effect at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | vec_i carries a vector this cycle |
| vec_i | input | 16 | Input vector, expected to have five bits set |
| valid_o | output | 1 | idx_o and err_o carry a result |
| idx_o | output | 20 | Five 4-bit indices, highest first |
| err_o | output | 1 | The input did not have exactly five bits set |

## Verification
Every result arrives exactly two rising edges after its vector is captured. The first edge registers the table lookups and the popcount flag, and the second registers the merged word. The bench drives inputs on falling edges and streams one vector per cycle. At each falling edge it checks the vector it drove two falling edges earlier, so back-to-back inputs are covered by the same timing. For the valid-pulse and reset tests, the bench samples at a falling edge, or shortly after it when reset is lowered asynchronously.

// File: rtl/fh_pkg.sv
package fh_pkg;
  localparam int IN_W   = 16;
  localparam int HOT    = 5;
  localparam int BYTE_W = IN_W / 2;
  localparam int POS_W  = $clog2(IN_W);
  localparam int CNT_W  = $clog2(HOT + 1);
  localparam int WORD_W = HOT * POS_W;
  localparam int ENT_W  = WORD_W + CNT_W;
  localparam int DEPTH  = 1 << BYTE_W;

  // low side: ascending indices from bits [POS_W-1:0] up, count on top
  // high side: descending indices from the top field down, count field zero
  function automatic logic [ENT_W-1:0] make_entry(int addr, bit low_side);
    logic [ENT_W-1:0] e;
    int n;
    e = '0;
    n = 0;
    if (low_side) begin
      for (int b = 0; b < BYTE_W; b++) begin
        if (((addr >> b) & 1) == 1 && n < HOT) begin
          e[POS_W*n +: POS_W] = POS_W'(b);
          n++;
        end
      end
      e[ENT_W-1 -: CNT_W] = CNT_W'(n);
    end else begin
      for (int b = BYTE_W - 1; b >= 0; b--) begin
        if (((addr >> b) & 1) == 1 && n < HOT) begin
          e[WORD_W-POS_W*(n+1) +: POS_W] = POS_W'(b + BYTE_W);
          n++;
        end
      end
    end
    return e;
  endfunction

  function automatic logic [DEPTH*ENT_W-1:0] make_table(bit low_side);
    logic [DEPTH*ENT_W-1:0] t;
    t = '0;
    for (int a = 0; a < DEPTH; a++) t[a*ENT_W +: ENT_W] = make_entry(a, low_side);
    return t;
  endfunction
endpackage

// File: rtl/fh_byte_table.sv
module fh_byte_table
  import fh_pkg::*;
#(
  parameter bit LOW_SIDE = 1'b1,
  parameter int OUT_W    = ENT_W
) (
  input  logic [BYTE_W-1:0] addr_i,
  output logic [OUT_W-1:0]  ent_o
);
  localparam logic [DEPTH*ENT_W-1:0] TBL = make_table(LOW_SIDE);

  logic [ENT_W-1:0] ent_full;
  assign ent_full = TBL[int'(addr_i)*ENT_W +: ENT_W];
  assign ent_o    = OUT_W'(ent_full);
endmodule

// File: rtl/fh_popchk.sv
module fh_popchk
  import fh_pkg::*;
(
  input  logic [IN_W-1:0] vec_i,
  output logic            bad_o
);
  logic [$clog2(IN_W+1)-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < IN_W; i++) cnt = cnt + {{($clog2(IN_W+1)-1){1'b0}}, vec_i[i]};
  end

  assign bad_o = (int'(cnt) != HOT);
endmodule

// File: rtl/fh_merge.sv
module fh_merge
  import fh_pkg::*;
(
  input  logic [WORD_W-1:0] lo_word_i,
  input  logic [CNT_W-1:0]  lo_cnt_i,
  input  logic [WORD_W-1:0] hi_word_i,
  output logic [WORD_W-1:0] word_o
);
  // slot 0 is the top field; low data wins from slot HOT-lo_cnt downward
  for (genvar k = 0; k < HOT; k++) begin : g_slot
    localparam int LSB = WORD_W - POS_W*(k+1);
    logic take_lo;
    assign take_lo = (int'(lo_cnt_i) + k >= HOT);
    assign word_o[LSB +: POS_W] = take_lo ? lo_word_i[LSB +: POS_W] : hi_word_i[LSB +: POS_W];
  end
endmodule

// File: rtl/fh_index_encoder.sv
module fh_index_encoder
  import fh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IN_W-1:0]   vec_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] idx_o,
  output logic              err_o
);
  logic [ENT_W-1:0]  lo_ent;
  logic [WORD_W-1:0] hi_ent;
  logic              bad;

  fh_byte_table #(.LOW_SIDE(1'b1), .OUT_W(ENT_W)) u_lo_tbl (
    .addr_i (vec_i[BYTE_W-1:0]),
    .ent_o  (lo_ent)
  );

  fh_byte_table #(.LOW_SIDE(1'b0), .OUT_W(WORD_W)) u_hi_tbl (
    .addr_i (vec_i[IN_W-1:BYTE_W]),
    .ent_o  (hi_ent)
  );

  fh_popchk u_popchk (
    .vec_i (vec_i),
    .bad_o (bad)
  );

  // stage 1: registered lookups
  logic [ENT_W-1:0]  s1_lo;
  logic [WORD_W-1:0] s1_hi;
  logic              s1_vld, s1_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_err <= 1'b0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      s1_vld  <= valid_i;
      s1_err  <= valid_i & bad;
      valid_o <= s1_vld;
      err_o   <= s1_vld & s1_err;
    end
  end

  always_ff @(posedge clk_i) begin
    s1_lo <= lo_ent;
    s1_hi <= hi_ent;
  end

  // stage 2: per-bit 2:1 merge
  logic [WORD_W-1:0] merged;

  fh_merge u_merge (
    .lo_word_i (s1_lo[WORD_W-1:0]),
    .lo_cnt_i  (s1_lo[ENT_W-1 -: CNT_W]),
    .hi_word_i (s1_hi),
    .word_o    (merged)
  );

  always_ff @(posedge clk_i) idx_o <= merged;

  AST_DESCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o) |-> (idx_o[19:16] > idx_o[15:12]) && (idx_o[15:12] > idx_o[11:8]) &&
                            (idx_o[11:8] > idx_o[7:4]) && (idx_o[7:4] > idx_o[3:0])); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o); // R5
  AST_ERR_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o); // R6
  AST_ERR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 (err_o == ($countones($past(vec_i, 2)) != HOT))); // R6
endmodule

// File: tb/fh_index_encoder_tb.sv
module fh_index_encoder_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 12;

  localparam logic [15:0] VEC [NV] = '{
    16'hC007, 16'h001F, 16'hF800, 16'h8423, 16'h0F80, 16'h5540,
    16'h00F8, 16'h1234, 16'h0000, 16'hC001, 16'hFFFF, 16'h003F
  };
  localparam string TAG [NV] = '{
    "R2", "R3", "R3", "R1", "R3", "R1",
    "R3", "R4", "R7", "R7", "R6", "R6"
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] vec_i = '0;
  logic        valid_o;
  logic [19:0] idx_o;
  logic        err_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fh_index_encoder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .vec_i(vec_i),
    .valid_o(valid_o), .idx_o(idx_o), .err_o(err_o)
  );

  function automatic int popc(logic [15:0] v);
    int c = 0;
    for (int b = 0; b < 16; b++) c += int'(v[b]);
    return c;
  endfunction

  // high-byte indices from the top field down, low-byte from the bottom field up
  function automatic logic [19:0] model(logic [15:0] v);
    logic [19:0] r = '0;
    int n = 0;
    int m = 0;
    for (int b = 15; b >= 8; b--) if (v[b] && n < 5) begin r[4*(4-n) +: 4] = 4'(b); n++; end
    for (int b = 0; b < 8; b++)   if (v[b] && m < 5) begin r[4*m +: 4] = 4'(b); m++; end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_result(int i);
    chk({TAG[i], " valid"}, 32'(valid_o), 32'd1);
    chk({TAG[i], " err"}, 32'(err_o), 32'(popc(VEC[i]) != 5));
    if (popc(VEC[i]) <= 5) chk({TAG[i], " idx"}, 32'(idx_o), 32'(model(VEC[i])));
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R8 reset valid", 32'(valid_o), 32'd0);
    chk("R8 reset err", 32'(err_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // streamed table, one vector per cycle (R4)
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) check_result(i - 2);
      if (i < NV) begin
        valid_i = 1'b1;
        vec_i   = VEC[i];
      end else begin
        valid_i = 1'b0;
        vec_i   = '0;
      end
      @(negedge clk_i);
    end
    chk("R5 idle after stream", 32'(valid_o), 32'd0);

    // single pulse, R5
    valid_i = 1'b1; vec_i = 16'h8421 | 16'h0002;
    @(negedge clk_i);
    valid_i = 1'b0; vec_i = 16'hFFFF;
    chk("R5 not yet", 32'(valid_o), 32'd0);
    @(negedge clk_i);
    chk("R5 pulse", 32'(valid_o), 32'd1);
    chk("R1 pulse idx", 32'(idx_o), 32'hFA510);
    chk("R6 pulse err", 32'(err_o), 32'd0);
    @(negedge clk_i);
    chk("R5 pulse end", 32'(valid_o), 32'd0);
    chk("R6 no err when idle", 32'(err_o), 32'd0);

    // asynchronous reset mid-flight, R8
    valid_i = 1'b1; vec_i = 16'h0007;
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R6 bad input flagged", 32'(err_o), 32'd1);
    rst_ni = 1'b0;
    #1;
    chk("R8 async valid", 32'(valid_o), 32'd0);
    chk("R8 async err", 32'(err_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 stays clear", 32'(valid_o), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule